// File: doc/BRIEF.md
# Synchronous Character Sync Detector

This block sits ahead of a synchronous serial receiver and decides where character assembly begins. It runs on the receive clock and takes one data bit per cycle. It keeps a short history of received bits and compares it against programmable sync patterns. It can also react to an external active-low sync strobe. It reports the result on four outputs: an unlatched active-low sync-detected line, a one-cycle character-start strobe, a hunt status bit, and a transition flag used only in asynchronous operation.

A small state machine has two states, HUNT and LOCKED. Reset and the hunt command both put it in HUNT. The transition named *lock* (HUNT to LOCKED) fires on the first trigger seen while hunting, and it raises the character-start strobe for that cycle. The transition named *rehunt* (LOCKED to HUNT) fires on the hunt command. In every other case each state holds: HUNT waits for a trigger, and LOCKED ignores further pattern matches. The trigger depends on the mode: in the three internal modes it is a pattern match, and in external mode it is a detected falling edge of the synchronized sync input.

Top module: `sync_char_detector`

## Requirements
- R1: During and right after reset, the state is HUNT, so the hunt status reads 1. At the same time sync_out_n reads 1, char_start reads 0 and ext_change reads 0.
- R2: Mode code 0 is monosync. Bits shift in with the newest bit in the least significant position, so the first received bit of a byte is its MSB. Once at least 8 bits have been received since reset, sync_out_n is 0 in the cycle right after a clock edge that leaves the last 8 bits equal to pat_a.
- R3: Mode code 1 is bisync. Once at least 16 bits have been received, sync_out_n is 0 when the last 16 bits equal {pat_a, pat_b}, with pat_a received first.
- R4: Mode code 2 is flag mode. sync_out_n is 0 when the last 8 bits equal 8'h7E.
- R5: The sync indication is not latched. It lasts only for the cycles in which the match holds, and it fires on every occurrence in the bit stream, aligned to a character boundary or not.
- R6: The first trigger while in HUNT raises char_start for exactly one cycle. The hunt status reads 0 from the next cycle on.
- R7: In LOCKED, later matches still drive sync_out_n low but never raise char_start.
- R8: hunt_cmd puts the state in HUNT, so the hunt status reads 1 from the next cycle on. The command takes priority over a trigger in the same cycle: char_start stays 0 while hunt_cmd is high.
- R9: Mode code 3 is external sync. ext_sync_n passes through a two-stage synchronizer. char_start pulses in the cycle after the second rising clock edge that samples the input low, provided the state is HUNT. sync_out_n stays 1 in this mode.
- R10: Mode code 4 is asynchronous. The hunt status shows the synchronized input level (1 while ext_sync_n is low), two edges late. ext_change pulses for one cycle on each input transition. sync_out_n stays 1, char_start stays 0, and the hunt state is left as it was.
- R11: Mode codes 5 to 7 behave exactly like asynchronous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low reset |
| mode | input | 3 | Mode code: 0 mono, 1 bisync, 2 flag, 3 external, 4 async (5-7 async) |
| rx_bit | input | 1 | Serial data bit, one per cycle |
| pat_a | input | 8 | First sync pattern |
| pat_b | input | 8 | Second sync pattern (bisync) |
| hunt_cmd | input | 1 | Enter-hunt command |
| ext_sync_n | input | 1 | External active-low sync input |
| sync_out_n | output | 1 | Active-low unlatched sync-detected |
| char_start | output | 1 | Character-start strobe |
| hunt_stat | output | 1 | Sync/hunt status bit |
| ext_change | output | 1 | Input transition flag (async modes) |

## Verification
The bench builds the block with its default parameters: an 8-bit pattern width and a two-stage synchronizer. At these values the bench uses the flag pattern 8'h7E, and the external-edge timing can be counted exactly, so all five modes are within reach. An alternating pattern in monosync produces a match every two bits, which exercises the off-boundary and unlatched behaviour. A hunt command issued in the same cycle as a completing pattern exercises the priority rule.

// File: rtl/scd_pkg.sv
package scd_pkg;

    localparam logic [2:0] MODE_MONO  = 3'd0;
    localparam logic [2:0] MODE_BI    = 3'd1;
    localparam logic [2:0] MODE_FLAG  = 3'd2;
    localparam logic [2:0] MODE_EXT   = 3'd3;
    localparam logic [2:0] MODE_ASYNC = 3'd4;

    typedef enum logic {
        ST_HUNT   = 1'b0,
        ST_LOCKED = 1'b1
    } hunt_state_e;

    function automatic logic is_internal(input logic [2:0] m);
        return (m == MODE_MONO) || (m == MODE_BI) || (m == MODE_FLAG);
    endfunction

    function automatic logic is_async(input logic [2:0] m);
        return m > MODE_EXT;
    endfunction

endpackage

// File: rtl/scd_history.sv
module scd_history #(
    parameter int PAT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_bit,
    output logic [2*PAT_W-1:0]   hist,
    output logic                 have_one,
    output logic                 have_two
);
    localparam int HW = 2 * PAT_W;
    localparam int CW = $clog2(HW + 1);

    logic [CW-1:0] fill;

    // newest bit enters at bit 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist <= '0;
            fill <= '0;
        end else begin
            hist <= {hist[HW-2:0], rx_bit};
            if (fill != CW'(HW))
                fill <= fill + 1'b1;
        end
    end

    assign have_one = (fill >= CW'(PAT_W));
    assign have_two = (fill == CW'(HW));

    // R2: a full pair of patterns implies a full single pattern
    p_fill_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        have_two |-> have_one);

endmodule

// File: rtl/scd_matcher.sv
module scd_matcher #(
    parameter int PAT_W = 8
) (
    input  logic [2:0]         mode,
    input  logic [2*PAT_W-1:0] hist,
    input  logic               have_one,
    input  logic               have_two,
    input  logic [PAT_W-1:0]   pat_a,
    input  logic [PAT_W-1:0]   pat_b,
    output logic               hit
);
    import scd_pkg::*;

    localparam logic [PAT_W-1:0] FLAG = {1'b0, {(PAT_W-2){1'b1}}, 1'b0};

    always_comb begin
        hit = 1'b0;
        case (mode)
            MODE_MONO: hit = have_one && (hist[PAT_W-1:0] == pat_a);
            MODE_BI:   hit = have_two && (hist == {pat_a, pat_b});
            MODE_FLAG: hit = have_one && (hist[PAT_W-1:0] == FLAG);
            default:   hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/scd_ext_sync.sv
module scd_ext_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_n,
    output logic lvl_n,
    output logic fall,
    output logic toggle
);
    localparam int CH = SYNC_STAGES + 1;

    logic [CH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chain <= '1;
        else
            chain <= {chain[CH-2:0], ext_n};
    end

    assign lvl_n  = chain[SYNC_STAGES-1];
    assign fall   = chain[SYNC_STAGES] & ~chain[SYNC_STAGES-1];
    assign toggle = chain[SYNC_STAGES] ^ chain[SYNC_STAGES-1];

    generate
        if (SYNC_STAGES == 2) begin : g_chk
            // R9: an edge is only seen after the pin was sampled low two edges earlier
            p_fall_after_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
                fall |-> !$past(ext_n, 2));
        end
    endgenerate

endmodule

// File: rtl/scd_hunt_fsm.sv
module scd_hunt_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic hunt_cmd,
    output logic start,
    output logic in_hunt
);
    import scd_pkg::*;

    hunt_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (!hunt_cmd && trig)
                    state_d = ST_LOCKED;     // lock
            end
            ST_LOCKED: begin
                if (hunt_cmd)
                    state_d = ST_HUNT;       // rehunt
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_HUNT;
        else
            state_q <= state_d;
    end

    always_comb begin
        start   = 1'b0;
        in_hunt = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                in_hunt = 1'b1;
                start   = trig & ~hunt_cmd;
            end
            ST_LOCKED: begin
                in_hunt = 1'b0;
            end
        endcase
    end

    // R6: a start strobe leaves the hunt
    p_start_locks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state_q == ST_LOCKED));
    // R8: the command always returns to hunt
    p_cmd_hunts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_cmd |=> (state_q == ST_HUNT));
    // R7: only the command leaves LOCKED
    p_locked_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && !hunt_cmd) |=> (state_q == ST_LOCKED));

endmodule

// File: rtl/sync_char_detector.sv
module sync_char_detector #(
    parameter int PAT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode,
    input  logic             rx_bit,
    input  logic [PAT_W-1:0] pat_a,
    input  logic [PAT_W-1:0] pat_b,
    input  logic             hunt_cmd,
    input  logic             ext_sync_n,
    output logic             sync_out_n,
    output logic             char_start,
    output logic             hunt_stat,
    output logic             ext_change
);
    import scd_pkg::*;

    logic [2*PAT_W-1:0] hist;
    logic have_one, have_two;
    logic hit;
    logic lvl_n, fall, toggle;
    logic trig, start, in_hunt;
    logic internal_m, async_m, ext_m;

    assign internal_m = is_internal(mode);
    assign async_m    = is_async(mode);
    assign ext_m      = (mode == MODE_EXT);

    scd_history #(.PAT_W(PAT_W)) u_hist (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit),
        .hist(hist), .have_one(have_one), .have_two(have_two)
    );

    scd_matcher #(.PAT_W(PAT_W)) u_match (
        .mode(mode), .hist(hist), .have_one(have_one), .have_two(have_two),
        .pat_a(pat_a), .pat_b(pat_b), .hit(hit)
    );

    scd_ext_sync #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
        .clk(clk), .rst_n(rst_n), .ext_n(ext_sync_n),
        .lvl_n(lvl_n), .fall(fall), .toggle(toggle)
    );

    always_comb begin
        trig = 1'b0;
        if (internal_m)
            trig = hit;
        else if (ext_m)
            trig = fall;
    end

    scd_hunt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .trig(trig), .hunt_cmd(hunt_cmd),
        .start(start), .in_hunt(in_hunt)
    );

    assign sync_out_n = ~(internal_m & hit);
    assign char_start = start;
    assign hunt_stat  = async_m ? ~lvl_n : in_hunt;
    assign ext_change = async_m & toggle;

    // R10: no sync indication and no start in the pin-driven modes
    p_quiet_async_r10: assert property (@(posedge clk) disable iff (!rst_n)
        async_m |-> (sync_out_n && !char_start));
    // R9: external mode never drives the sync output
    p_ext_no_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_m |-> sync_out_n);
    // R5: a start strobe in an internal mode coincides with a match
    p_start_with_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (char_start && internal_m) |-> !sync_out_n);

endmodule

// File: tb/sync_char_detector_bench.sv
module sync_char_detector_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'd0;
    logic       rx_bit = 1'b0;
    logic [7:0] pat_a = 8'h00;
    logic [7:0] pat_b = 8'h00;
    logic       hunt_cmd = 1'b0;
    logic       ext_sync_n = 1'b1;
    logic       sync_out_n, char_start, hunt_stat, ext_change;

    sync_char_detector u_sync_char_detector (
        .clk(clk), .rst_n(rst_n), .mode(mode), .rx_bit(rx_bit),
        .pat_a(pat_a), .pat_b(pat_b), .hunt_cmd(hunt_cmd),
        .ext_sync_n(ext_sync_n), .sync_out_n(sync_out_n),
        .char_start(char_start), .hunt_stat(hunt_stat), .ext_change(ext_change)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic  sn, cs, hs, ec;
        string req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    string cur_req = "R1";

    logic [2:0]  cfg_mode = 3'd0;
    logic [7:0]  cfg_a = 8'h00, cfg_b = 8'h00;

    // model state
    logic [15:0] m_hist = '0;
    int          m_fill = 0;
    logic        m_hunt = 1'b1;
    logic        m_s1 = 1'b1, m_s2 = 1'b1, m_s3 = 1'b1;

    function automatic logic m_match(logic [2:0] md);
        case (md)
            3'd0: return (m_fill >= 8) && (m_hist[7:0] == cfg_a);
            3'd1: return (m_fill >= 16) && (m_hist == {cfg_a, cfg_b});
            3'd2: return (m_fill >= 8) && (m_hist[7:0] == 8'h7E);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic m_trig(logic [2:0] md);
        if (md <= 3'd2) return m_match(md);
        if (md == 3'd3) return m_s3 && !m_s2;
        return 1'b0;
    endfunction

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic step(logic b, logic hc, logic pin);
        exp_t e;
        logic st_old;
        @(negedge clk);
        rst_n = 1'b1;
        mode = cfg_mode; pat_a = cfg_a; pat_b = cfg_b;
        rx_bit = b; hunt_cmd = hc; ext_sync_n = pin;
        st_old = m_hunt && !hc && m_trig(cfg_mode);
        if (hc) m_hunt = 1'b1;
        else if (st_old) m_hunt = 1'b0;
        m_hist = {m_hist[14:0], b};
        if (m_fill < 16) m_fill++;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin;
        e.sn  = !((cfg_mode <= 3'd2) && m_match(cfg_mode));
        e.cs  = m_hunt && !hc && m_trig(cfg_mode);
        e.hs  = (cfg_mode > 3'd3) ? !m_s2 : m_hunt;
        e.ec  = (cfg_mode > 3'd3) && (m_s2 != m_s3);
        e.req = cur_req;
        q.push_back(e);
    endtask

    task automatic send_byte(logic [7:0] v);
        for (int i = 7; i >= 0; i--) step(v[i], 1'b0, 1'b1);
    endtask

    // monitor: compare a quarter period after each rising edge
    always @(posedge clk) begin
        #5;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.req, "sync_out_n", sync_out_n, e.sn);
            chk(e.req, "char_start(R6)", char_start, e.cs);
            chk(e.req, "hunt_stat(R8)", hunt_stat, e.hs);
            chk(e.req, "ext_change(R10)", ext_change, e.ec);
        end
    end

    bit done = 0;
    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #5;
        chk("R1", "hunt_stat", hunt_stat, 1'b1);
        chk("R1", "sync_out_n", sync_out_n, 1'b1);
        chk("R1", "char_start", char_start, 1'b0);
        chk("R1", "ext_change", ext_change, 1'b0);

        // R2 and R6: monosync, first match exits hunt
        cur_req = "R2"; cfg_mode = 3'd0; cfg_a = 8'hA5;
        send_byte(8'h00);
        send_byte(8'hA5);
        send_byte(8'h0F);
        // R7: off-boundary repeat in LOCKED gives sync only
        cur_req = "R7";
        step(1'b0, 1'b0, 1'b1); step(1'b1, 1'b0, 1'b1); step(1'b1, 1'b0, 1'b1);
        send_byte(8'hA5);
        // R5: alternating pattern matches every two bits
        cur_req = "R5"; cfg_a = 8'hAA;
        send_byte(8'hAA); send_byte(8'hAA); send_byte(8'h00);

        // R8: hunt command coinciding with a completing pattern
        cur_req = "R8";
        for (int i = 7; i >= 1; i--) step(cfg_a[i], 1'b0, 1'b1);
        step(cfg_a[0], 1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        send_byte(8'h00);
        send_byte(8'hAA);
        step(1'b0, 1'b1, 1'b1);

        // R3: bisync
        cur_req = "R3"; cfg_mode = 3'd1; cfg_a = 8'hE1; cfg_b = 8'h3C;
        send_byte(8'h3C); send_byte(8'hE1);
        send_byte(8'hE1); send_byte(8'h3C);
        send_byte(8'h00);
        step(1'b0, 1'b1, 1'b1);

        // R4: flag mode
        cur_req = "R4"; cfg_mode = 3'd2;
        send_byte(8'h7F); send_byte(8'h7E); send_byte(8'h7E);
        step(1'b0, 1'b1, 1'b1);

        // R9: external sync
        cur_req = "R9"; cfg_mode = 3'd3;
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1);

        // R10: asynchronous mode
        cur_req = "R10"; cfg_mode = 3'd4;
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1);
        send_byte(8'h7E);
        step(1'b0, 1'b0, 1'b0); step(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1);

        // R11: reserved codes act as async
        cur_req = "R11"; cfg_mode = 3'd7;
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1);
        cfg_mode = 3'd5;
        step(1'b0, 1'b0, 1'b0); step(1'b0, 1'b0, 1'b0); step(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1);

        // back to monosync: hunt state survived the pin activity (R10)
        cur_req = "R10"; cfg_mode = 3'd0; cfg_a = 8'h3C;
        send_byte(8'h3C); send_byte(8'h00);

        @(posedge clk); #6;
        @(posedge clk); #6;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule